// File: doc/BRIEF.md
# High-Speed Host Periodic Time Base

This block keeps the time base that a high-speed USB host uses to walk its periodic schedule. It holds a 14-bit frame index. The three low bits count the eight micro-frames of a frame, and the eleven high bits count host frames. Each micro-frame tick from the bus timer advances the index by one. The index advances only while the run enable is high. Software can load a new index at any time.

Beside the index sits a shadow bus-frame number. The SOF token generator places this number in each start-of-frame token. It advances when the micro-frame field steps from 0 to 1, and not when the field wraps from 7 to 0. As a result, the bus frame trails the host frame by exactly one micro-frame. Each bus frame number appears in eight consecutive SOF tokens.

Two strobes mark the boundaries. One marks each host-frame boundary and the other marks each bus-frame boundary. A small two-state machine, HALTED and RUNNING, follows the run enable and decides whether ticks count. The transition HALTED to RUNNING is taken on a clock edge with the run enable high. The transition RUNNING to HALTED is taken on an edge with it low.

Top module: `ufi_timebase`

## Requirements
- R1: A synchronous reset sets the index to 0, the bus frame number to 2047 (the value consistent with index 0), both strobes to 0 and the state to HALTED.
- R2: In RUNNING, each cycle with the tick high and no write adds one to the 14-bit index. Bits [2:0] are the micro-frame field.
- R3: The frame field, index bits [13:3], changes on a tick only when the micro-frame field wraps from 7 to 0, and then it increases by one.
- R4: The bus frame number increases by one only on a tick that moves the micro-frame field from 0 to 1. At all times it equals the frame field when the micro-frame field is nonzero, and equals the frame field minus 1 (mod 2048) when it is 0.
- R5: In HALTED, ticks are ignored and the index and bus frame number hold.
- R6: A write loads the index from the write port on the next edge. It takes priority over a tick in the same cycle.
- R7: A write loads the bus frame number with the written frame field minus 1 (mod 2048) if the written micro-frame field is 0, and with the written frame field otherwise.
- R8: The index wraps from 16383 to 0, and the bus frame number wraps from 2047 to 0.
- R9: The host-frame strobe is high for exactly the one cycle after a tick that wraps the micro-frame field to 0.
- R10: The bus-frame strobe is high for exactly the one cycle after a tick that increments the bus frame number.
- R11: The running output is high in RUNNING. The state follows the run enable with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable; selects RUNNING on the next edge |
| uf_tick | input | 1 | One-cycle micro-frame tick |
| wr_en | input | 1 | Software write strobe for the index |
| wr_index | input | 14 | Value loaded into the index on a write |
| index | output | 14 | Frame index: [13:3] frame, [2:0] micro-frame |
| sof_frame | output | 11 | Bus frame number for SOF tokens |
| frame_strobe | output | 1 | Host-frame boundary pulse |
| bus_frame_strobe | output | 1 | Bus-frame boundary pulse |
| running | output | 1 | High in RUNNING state |

## Verification
The corner that is hardest to reach is the double wrap at the top of the index. The index rolls from 16383 to 0 while the bus frame number sits at 2047, and one tick later the bus frame number itself rolls to 0. Counting there from reset would take more than sixteen thousand ticks. The bench instead writes an index of frame 2047, micro-frame 6, and then ticks through the wrap. The bench also writes micro-frame-0 values, including index 0, to exercise the minus-one load and its wrap to 2047.

// File: rtl/ufi_pkg.sv
package ufi_pkg;
    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } ufi_state_e;
endpackage

// File: rtl/ufi_uframe_ctr.sv
module ufi_uframe_ctr #(
    parameter int UF_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [UF_W-1:0] load_val,
    input  logic            adv,
    output logic [UF_W-1:0] count,
    output logic            wrap,
    output logic            step01
);
    localparam logic [UF_W-1:0] UF_MAX = '1;
    localparam logic [UF_W-1:0] UF_ONE = UF_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (adv)  count <= count + UF_ONE;
    end

    // carry out of the micro-frame field, and the first step inside a frame
    always_comb begin
        wrap   = adv && !load && (count == UF_MAX);
        step01 = adv && !load && (count == '0);
    end
endmodule

// File: rtl/ufi_frame_reg.sv
module ufi_frame_reg #(
    parameter int FR_W     = 11,
    parameter bit RST_ONES = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [FR_W-1:0] load_val,
    input  logic            inc,
    output logic [FR_W-1:0] value
);
    localparam logic [FR_W-1:0] FR_ONE = FR_W'(1);
    logic [FR_W-1:0] rst_val;

    generate
        if (RST_ONES) begin : g_ones
            assign rst_val = '1;
        end else begin : g_zero
            assign rst_val = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       value <= rst_val;
        else if (load) value <= load_val;
        else if (inc)  value <= value + FR_ONE;
    end
endmodule

// File: rtl/ufi_timebase.sv
module ufi_timebase #(
    parameter int UF_W  = 3,
    parameter int FR_W  = 11,
    localparam int IDX_W = UF_W + FR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             uf_tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    output logic [IDX_W-1:0] index,
    output logic [FR_W-1:0]  sof_frame,
    output logic             frame_strobe,
    output logic             bus_frame_strobe,
    output logic             running
);
    import ufi_pkg::*;

    localparam logic [FR_W-1:0] FR_ONE = FR_W'(1);

    ufi_state_e state_q, state_d;
    logic            advance;
    logic [UF_W-1:0] uf_count;
    logic [FR_W-1:0] fr_count;
    logic            uf_wrap, uf_step01;
    logic [UF_W-1:0] wr_uf;
    logic [FR_W-1:0] wr_fr, sof_load_val;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALTED;
        else     state_q <= state_d;
    end

    // next state and state-decoded outputs
    always_comb begin
        state_d = state_q;
        running = 1'b0;
        unique case (state_q)
            ST_HALTED: begin
                if (run_en) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                running = 1'b1;
                if (!run_en) state_d = ST_HALTED;
            end
        endcase
        advance = running && uf_tick && !wr_en;
    end

    // split the written index and pick the shadow value that keeps the lag
    always_comb begin
        wr_uf        = wr_index[UF_W-1:0];
        wr_fr        = wr_index[IDX_W-1:UF_W];
        sof_load_val = (wr_uf == '0) ? (wr_fr - FR_ONE) : wr_fr;
    end

    ufi_uframe_ctr #(.UF_W(UF_W)) u_uframe (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_val (wr_uf),
        .adv      (advance),
        .count    (uf_count),
        .wrap     (uf_wrap),
        .step01   (uf_step01)
    );

    ufi_frame_reg #(.FR_W(FR_W), .RST_ONES(1'b0)) u_host_frame (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_val (wr_fr),
        .inc      (uf_wrap),
        .value    (fr_count)
    );

    ufi_frame_reg #(.FR_W(FR_W), .RST_ONES(1'b1)) u_bus_frame (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .load_val (sof_load_val),
        .inc      (uf_step01),
        .value    (sof_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_strobe     <= 1'b0;
            bus_frame_strobe <= 1'b0;
        end else begin
            frame_strobe     <= uf_wrap;
            bus_frame_strobe <= uf_step01;
        end
    end

    assign index = {fr_count, uf_count};
endmodule

// File: rtl/ufi_timebase_chk.sv
module ufi_timebase_chk #(
    parameter int UF_W  = 3,
    parameter int FR_W  = 11,
    localparam int IDX_W = UF_W + FR_W
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             uf_tick,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_index,
    input logic [IDX_W-1:0] index,
    input logic [FR_W-1:0]  sof_frame,
    input logic             frame_strobe,
    input logic             bus_frame_strobe,
    input logic             running
);
    localparam logic [FR_W-1:0]  F1 = FR_W'(1);
    localparam logic [IDX_W-1:0] I1 = IDX_W'(1);

    // R2
    idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (running && uf_tick && !wr_en) |=> (index == $past(index) + I1));

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && uf_tick && !wr_en && index[UF_W-1:0] != '1)
        |=> (index[IDX_W-1:UF_W] == $past(index[IDX_W-1:UF_W])));

    // R4
    sof_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (index[UF_W-1:0] == '0) ? (sof_frame == index[IDX_W-1:UF_W] - F1)
                                : (sof_frame == index[IDX_W-1:UF_W]));

    // R5
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_en) |=> (index == $past(index)));

    // R6
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (index == $past(wr_index)));

    // R9
    frame_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_strobe |-> (index[UF_W-1:0] == '0));

    // R10
    bus_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_frame_strobe |-> (index[UF_W-1:0] == UF_W'(1)));

    // R11
    run_follow_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |=> running);
endmodule

bind ufi_timebase ufi_timebase_chk #(.UF_W(UF_W), .FR_W(FR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .run_en           (run_en),
    .uf_tick          (uf_tick),
    .wr_en            (wr_en),
    .wr_index         (wr_index),
    .index            (index),
    .sof_frame        (sof_frame),
    .frame_strobe     (frame_strobe),
    .bus_frame_strobe (bus_frame_strobe),
    .running          (running)
);

// File: tb/ufi_timebase_test.sv
module ufi_timebase_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        uf_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_index = '0;
    logic [13:0] index;
    logic [10:0] sof_frame;
    logic        frame_strobe, bus_frame_strobe, running;

    int n_checks = 0;
    int n_fail = 0;

    logic [13:0] exp_idx;
    logic [10:0] exp_sof;
    logic        exp_run;

    always #2.5 clk = ~clk;

    ufi_timebase uut (
        .clk(clk), .rst(rst), .run_en(run_en), .uf_tick(uf_tick),
        .wr_en(wr_en), .wr_index(wr_index), .index(index),
        .sof_frame(sof_frame), .frame_strobe(frame_strobe),
        .bus_frame_strobe(bus_frame_strobe), .running(running)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " index"}, 32'(index), 32'(exp_idx));
        chk({req, " sof_frame"}, 32'(sof_frame), 32'(exp_sof));
        chk({req, " running"}, 32'(running), 32'(exp_run));
    endtask

    // one tick, sample after the edge, then one idle cycle to see the strobes drop
    task automatic do_tick(input string req);
        logic fs, bs;
        @(negedge clk) uf_tick = 1'b1;
        @(negedge clk) uf_tick = 1'b0;
        fs = exp_run && (exp_idx[2:0] == 3'd7);
        bs = exp_run && (exp_idx[2:0] == 3'd0);
        if (exp_run) begin
            exp_idx = exp_idx + 14'd1;
            if (bs) exp_sof = exp_sof + 11'd1;
        end
        check_state(req);
        chk({req, " R9 frame_strobe"}, 32'(frame_strobe), 32'(fs));
        chk({req, " R10 bus_frame_strobe"}, 32'(bus_frame_strobe), 32'(bs));
        @(negedge clk);
        chk({req, " R9 frame_strobe drop"}, 32'(frame_strobe), 32'd0);
        chk({req, " R10 bus_frame_strobe drop"}, 32'(bus_frame_strobe), 32'd0);
    endtask

    task automatic do_write(input logic [13:0] v, input logic with_tick, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_index = v; uf_tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; uf_tick = 1'b0;
        exp_idx = v;
        exp_sof = (v[2:0] == 3'd0) ? (v[13:3] - 11'd1) : v[13:3];
        check_state(req);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_idx = '0; exp_sof = 11'd2047; exp_run = 1'b0;
        check_state("R1 reset");
        chk("R1 frame_strobe", 32'(frame_strobe), 32'd0);
        chk("R1 bus_frame_strobe", 32'(bus_frame_strobe), 32'd0);
    endtask

    task automatic t_halted_ignores;
        for (int i = 0; i < 3; i++) do_tick("R5 halted tick");
    endtask

    task automatic t_start;
        @(negedge clk) run_en = 1'b1;
        chk("R11 not yet running", 32'(running), 32'd0);
        @(negedge clk);
        exp_run = 1'b1;
        chk("R11 running", 32'(running), 32'd1);
    endtask

    task automatic t_count;
        for (int i = 0; i < 18; i++) do_tick("R2 R3 R4 count");
    endtask

    task automatic t_writes;
        do_write(14'h0458, 1'b0, "R7 write uf0");
        do_write(14'h045d, 1'b0, "R7 write uf5");
        do_write(14'h0000, 1'b0, "R7 write zero");
        do_tick("R4 step01 after zero");
        do_write(14'h1233, 1'b1, "R6 write beats tick");
        do_tick("R2 after write");
    endtask

    task automatic t_wrap;
        do_write(14'h3ffe, 1'b0, "R8 load top");
        do_tick("R8 to 16383");
        do_tick("R8 index wrap");
        do_tick("R8 sof wrap");
        chk("R8 sof wrapped to 0", 32'(sof_frame), 32'd0);
    endtask

    task automatic t_halt;
        @(negedge clk) run_en = 1'b0;
        @(negedge clk);
        exp_run = 1'b0;
        chk("R11 halted", 32'(running), 32'd0);
        for (int i = 0; i < 4; i++) do_tick("R5 hold after halt");
    endtask

    initial begin
        t_reset();
        t_halted_ignores();
        t_start();
        t_count();
        t_writes();
        t_wrap();
        t_halt();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule